// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one word written into its command register into a short, fully timed exchange on the raw pins of a NAND flash device. The exchange is made of up to four phases: a first command byte, one to five address bytes, a second command byte, and a wait for the device's ready/busy line. The command word decides which phases run. The first opcode comes from the command word itself. The second opcode and the address bytes come from registers that software loads beforehand.

Software enables the block in a control register, loads the address and opcode registers, and then writes the command word. It then polls the status register until the completion flag is set, and clears that flag by writing a 1 to it. A self-clearing reset request in the control register stops any operation in progress. The block moves no page data. It only sequences raw commands and addresses.

Register word indices on `reg_addr`: 0 control, 1 status, 2 command, 3 address low, 4 address high, 5 opcode set. Reads are combinational on `reg_rdata`.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, CE# and WE# are high, CLE, ALE and the IO output enable are low, and the control (index 0) and status (index 1) registers read 0.
- R2: When command bit 22 is set, the sequencer sends a command byte whose opcode is command bits [7:0], with CLE high. Every byte cycle drives WE# low for WE_LO_CYC clocks and then high for WE_HI_CYC clocks. IO, CLE and ALE are held steady across the WE# rising edge, which is where the device latches the byte.
- R3: When command bit 19 is set, ALE-qualified address bytes follow the first command. Their count is command bits [18:16] plus one, and any field value of 4 or more gives five. Bytes 1 to 4 are address-low (index 3) bits [7:0], [15:8], [23:16] and [31:24], in that order. Byte 5 is address-high (index 4) bits [7:0].
- R4: When command bit 24 is set, a second CLE byte follows the address bytes. Its opcode is opcode-set (index 5) bits [7:0], taken at the moment the command is accepted.
- R5: The opcode-set register stores bits [23:0] and reads them back, with bits [31:24] reading 0.
- R6: When command bit 23 is set, R/B# is ignored until SETTLE_CYC clocks after the last WE# high time ends. It is then sampled through two synchroniser flops. With R/B# already high, CE# rises WE_HI_CYC+SETTLE_CYC+2 clocks after the last WE# rise. After R/B# is released from low, CE# is still low 3 clocks later and high 4 clocks later.
- R7: Status bit 1 is set when an operation completes. Writing status with bit 1 set clears it. Writing 0 to bit 1 leaves it unchanged.
- R8: Status bit 4 reads 1 and CE# stays low for the whole operation. A command write made during this time sends no byte.
- R9: While control bit 0 (enable) is 0, command writes start nothing.
- R10: Writing control bit 1 aborts any operation at once (CE# high, busy 0) and clears status bit 1. Control bit 1 reads 1 until RST_CYC clocks have passed and then clears itself. Control bit 0 takes the written value.
- R11: Command bits [31:30] (the command type) do not change the sequence; every type is sequenced as a raw command.
- R12: CLE and ALE are never high together, and WE# is low only while CE# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_io_out | output | 8 | IO byte driven to the device |
| nand_io_oe | output | 1 | IO output enable |
| nand_rb_n | input | 1 | Ready/busy from the device, low while busy |

## Verification
The sequencer is driven with these phase mixes: a lone command, a full command/five-address/command read sequence with a non-raw type field, an address-and-second-command form without a first command, and an out-of-range address count. Comparing the captured byte streams shows whether phases are selected correctly and kept in order, whether address bytes are ordered correctly, and whether the count is clamped. Ready waits are tried both with R/B# already high and with R/B# released late. The first case measures the exact settle window and the second measures the synchroniser latency. Mid-operation command writes and a reset issued during a wait show apart the ignore, abort and flag-clearing behaviour.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  // register word indices
  localparam logic [2:0] RI_CTRL    = 3'd0;
  localparam logic [2:0] RI_STAT    = 3'd1;
  localparam logic [2:0] RI_CMD     = 3'd2;
  localparam logic [2:0] RI_ADDR_LO = 3'd3;
  localparam logic [2:0] RI_ADDR_HI = 3'd4;
  localparam logic [2:0] RI_OPSET   = 3'd5;

  // command word bit positions
  localparam int CB_ADDR = 19;
  localparam int CB_C1   = 22;
  localparam int CB_WAIT = 23;
  localparam int CB_C2   = 24;

  localparam int SB_DONE = 1;
  localparam int SB_BUSY = 4;
  localparam int CT_EN   = 0;
  localparam int CT_RST  = 1;

  // byte slots of one operation, in bus order
  localparam logic [2:0] SLOT_C1   = 3'd0;
  localparam logic [2:0] SLOT_C2   = 3'd6;
  localparam logic [2:0] SLOT_NONE = 3'd7;

  typedef struct packed {
    logic        c1;
    logic        addr;
    logic [2:0]  nadr;
    logic        c2;
    logic        wait_rb;
    logic [7:0]  op1;
    logic [7:0]  op2;
    logic [39:0] abytes;
  } op_cfg_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LO, S_HI, S_SETTLE, S_WAITRDY, S_FIN
  } seq_st_t;

  function automatic logic [2:0] addr_count(input logic [2:0] field);
    return (field >= 3'd4) ? 3'd5 : 3'(field + 3'd1);
  endfunction

  function automatic logic slot_on(input op_cfg_t c, input logic [2:0] s);
    if (s == SLOT_C1)   return c.c1;
    if (s == SLOT_C2)   return c.c2;
    if (s == SLOT_NONE) return 1'b1;
    return c.addr && (s <= c.nadr);
  endfunction

  // first enabled slot at or after 'from'
  function automatic logic [2:0] next_slot(input op_cfg_t c, input logic [2:0] from);
    logic [2:0] r;
    r = SLOT_NONE;
    for (int k = 6; k >= 0; k--) begin
      if (k >= int'(from) && slot_on(c, 3'(k))) r = 3'(k);
    end
    return r;
  endfunction

  function automatic logic [7:0] slot_byte(input op_cfg_t c, input logic [2:0] s);
    case (s)
      3'd0:    return c.op1;
      3'd1:    return c.abytes[7:0];
      3'd2:    return c.abytes[15:8];
      3'd3:    return c.abytes[23:16];
      3'd4:    return c.abytes[31:24];
      3'd5:    return c.abytes[39:32];
      3'd6:    return c.op2;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic slot_is_cmd(input logic [2:0] s);
    return (s == SLOT_C1) || (s == SLOT_C2);
  endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], async_in};
  end

  assign sync_out = sh[STAGES-1];
endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        busy,
  input  logic        op_done,
  output logic        abort,
  output logic        cmd_go,
  output op_cfg_t     cfg_new
);
  localparam int RW = $clog2(RST_CYC + 1);

  logic          en_q;
  logic [RW-1:0] rst_cnt;
  logic          rst_busy;
  logic          done_q;
  logic [31:0]   addr_lo_q;
  logic [7:0]    addr_hi_q;
  logic [23:0]   opset_q;

  // named events
  logic wr_ctrl, wr_stat, rst_req, cmd_wr;
  assign wr_ctrl  = reg_wr && (reg_addr == RI_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == RI_STAT);
  assign rst_req  = wr_ctrl && reg_wdata[CT_RST];
  assign cmd_wr   = reg_wr && (reg_addr == RI_CMD);
  assign rst_busy = (rst_cnt != '0);
  assign abort    = rst_req || rst_busy;
  assign cmd_go   = cmd_wr && en_q && !busy && !rst_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      rst_cnt   <= '0;
      done_q    <= 1'b0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      opset_q   <= '0;
    end else begin
      if (wr_ctrl) en_q <= reg_wdata[CT_EN];
      if (rst_req)       rst_cnt <= RW'(RST_CYC);
      else if (rst_busy) rst_cnt <= rst_cnt - RW'(1);
      if (abort)                              done_q <= 1'b0;
      else if (op_done)                       done_q <= 1'b1;
      else if (wr_stat && reg_wdata[SB_DONE]) done_q <= 1'b0;
      if (reg_wr && reg_addr == RI_ADDR_LO) addr_lo_q <= reg_wdata;
      if (reg_wr && reg_addr == RI_ADDR_HI) addr_hi_q <= reg_wdata[7:0];
      if (reg_wr && reg_addr == RI_OPSET)   opset_q   <= reg_wdata[23:0];
    end
  end

  always_comb begin
    cfg_new.c1      = reg_wdata[CB_C1];
    cfg_new.addr    = reg_wdata[CB_ADDR];
    cfg_new.nadr    = addr_count(reg_wdata[18:16]);
    cfg_new.c2      = reg_wdata[CB_C2];
    cfg_new.wait_rb = reg_wdata[CB_WAIT];
    cfg_new.op1     = reg_wdata[7:0];
    cfg_new.op2     = opset_q[7:0];
    cfg_new.abytes  = {addr_hi_q, addr_lo_q};
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RI_CTRL: begin
        reg_rdata[CT_EN]  = en_q;
        reg_rdata[CT_RST] = rst_busy;
      end
      RI_STAT: begin
        reg_rdata[SB_DONE] = done_q;
        reg_rdata[SB_BUSY] = busy;
      end
      RI_ADDR_LO: reg_rdata = addr_lo_q;
      RI_ADDR_HI: reg_rdata = {24'h0, addr_hi_q};
      RI_OPSET:   reg_rdata = {8'h0, opset_q};
      default:    reg_rdata = '0;
    endcase
  end

  AST_DONE_KEPT_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !reg_wdata[SB_DONE] && !op_done && !abort) |=> (done_q == $past(done_q))) else $error("done changed"); // R7
  AST_RST_FLAG_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_busy) |-> !rst_req) else $error("reset flag"); // R10
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int WE_LO_CYC  = 2,
  parameter int WE_HI_CYC  = 2,
  parameter int SETTLE_CYC = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  op_cfg_t    cfg_new,
  input  logic       abort,
  input  logic       rb_ready,
  output logic       busy,
  output logic       op_done,
  output logic       ce_n,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic [7:0] io_out,
  output logic       io_oe
);
  localparam int MAXA = (WE_LO_CYC > WE_HI_CYC) ? WE_LO_CYC : WE_HI_CYC;
  localparam int MAXC = (MAXA > SETTLE_CYC) ? MAXA : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seq_st_t       st;
  op_cfg_t       cfg;
  logic [2:0]    slot;
  logic [CW-1:0] cnt;

  logic [2:0] first_slot, follow_slot;
  logic       in_byte, lo_end, hi_end, settle_end;
  assign first_slot  = next_slot(cfg_new, 3'd0);
  assign follow_slot = next_slot(cfg, 3'(slot + 3'd1));
  assign in_byte     = (st == S_LO) || (st == S_HI);
  assign lo_end      = (st == S_LO) && (cnt == CW'(WE_LO_CYC - 1));
  assign hi_end      = (st == S_HI) && (cnt == CW'(WE_HI_CYC - 1));
  assign settle_end  = (st == S_SETTLE) && (cnt == CW'(SETTLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cfg  <= '0;
      slot <= SLOT_NONE;
      cnt  <= '0;
    end else if (abort) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          cfg  <= cfg_new;
          slot <= first_slot;
          cnt  <= '0;
          if (first_slot != SLOT_NONE) st <= S_LO;
          else if (cfg_new.wait_rb)    st <= S_SETTLE;
          else                         st <= S_FIN;
        end
        S_LO: begin
          if (lo_end) begin cnt <= '0; st <= S_HI; end
          else cnt <= cnt + CW'(1);
        end
        S_HI: begin
          if (hi_end) begin
            cnt  <= '0;
            slot <= follow_slot;
            if (follow_slot != SLOT_NONE) st <= S_LO;
            else if (cfg.wait_rb)         st <= S_SETTLE;
            else                          st <= S_FIN;
          end else cnt <= cnt + CW'(1);
        end
        S_SETTLE: begin
          if (settle_end) begin cnt <= '0; st <= S_WAITRDY; end
          else cnt <= cnt + CW'(1);
        end
        S_WAITRDY: if (rb_ready) st <= S_FIN;
        S_FIN:     st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign op_done = (st == S_FIN);
  assign ce_n    = !busy;
  assign we_n    = (st != S_LO);
  assign cle     = in_byte && slot_is_cmd(slot);
  assign ale     = in_byte && !slot_is_cmd(slot);
  assign io_oe   = in_byte;
  assign io_out  = in_byte ? slot_byte(cfg, slot) : 8'h00;

  // WE# low-run counter used by the width check
  logic [CW-1:0] lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lo_run <= '0;
    else if (!we_n) lo_run <= lo_run + CW'(1);
    else           lo_run <= '0;
  end

  AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (lo_run == CW'(WE_LO_CYC))) else $error("we low width"); // R2
  AST_IO_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($stable(io_out) && $stable(cle) && $stable(ale))) else $error("io moved"); // R2
  AST_READY_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && cfg.wait_rb) |-> $past(rb_ready)) else $error("done before ready"); // R6
  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)) else $error("cle and ale"); // R12
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n) else $error("we without ce"); // R12
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int WE_LO_CYC  = 2,
  parameter int WE_HI_CYC  = 2,
  parameter int SETTLE_CYC = 6,
  parameter int RST_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic        nand_rb_n
);
  logic    busy, op_done, abort, cmd_go, rb_ready;
  op_cfg_t cfg_new;

  nand_seq_regs #(.RST_CYC(RST_CYC)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .op_done(op_done), .abort(abort), .cmd_go(cmd_go), .cfg_new(cfg_new)
  );

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(nand_rb_n), .sync_out(rb_ready)
  );

  nand_seq_fsm #(
    .WE_LO_CYC(WE_LO_CYC), .WE_HI_CYC(WE_HI_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(cmd_go), .cfg_new(cfg_new), .abort(abort),
    .rb_ready(rb_ready), .busy(busy), .op_done(op_done), .ce_n(nand_ce_n),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .io_out(nand_io_out),
    .io_oe(nand_io_oe)
  );

  AST_RESET_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort) |-> !busy) else $error("busy after abort"); // R10
  AST_BUSY_KEEPS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort) |=> (busy || !nand_ce_n || op_done || $past(op_done))) else $error("ce"); // R8
endmodule

// File: tb/sim_nand_cmd_seq.sv
`timescale 1ns/100ps
module sim_nand_cmd_seq;
  localparam int WE_LO = 2, WE_HI = 2, SETTLE = 6, RSTC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_io_oe;
  logic [7:0]  nand_io_out;
  logic        nand_rb_n = 1'b1;

  always #2.5 clk = ~clk;

  nand_cmd_seq #(.WE_LO_CYC(WE_LO), .WE_HI_CYC(WE_HI), .SETTLE_CYC(SETTLE), .RST_CYC(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_rb_n(nand_rb_n)
  );

  int checks = 0, failures = 0;
  int lo_run = 0, rises = 0;
  logic prev_we = 1'b1;
  logic [9:0] cap_q[$];
  logic [9:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus monitor: model of the device latching bytes on WE# rise
  always @(negedge clk) if (rst_n) begin
    chk(!(nand_cle && nand_ale), "R12", "cle&ale", {nand_cle, nand_ale}, 0);
    chk(nand_we_n || !nand_ce_n, "R12", "we without ce", nand_ce_n, 0);
    if (!nand_we_n) lo_run++;
    else if (!prev_we) begin
      chk(lo_run == WE_LO, "R2", "we low width", lo_run, WE_LO);
      cap_q.push_back({nand_cle, nand_ale, nand_io_out});
      rises++;
      lo_run = 0;
    end
    prev_we = nand_we_n;
  end

  task automatic tick; @(negedge clk); #0.2; endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    tick; reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
    tick; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    tick; reg_addr = idx; #0.1; d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(input bit c1, input bit ad, input int nf,
                                     input bit c2, input bit wt, input logic [7:0] op);
    logic [31:0] w = 32'h0;
    w[22] = c1; w[19] = ad; w[18:16] = 3'(nf); w[24] = c2; w[23] = wt; w[7:0] = op;
    return w;
  endfunction

  task automatic ex_c(input logic [7:0] b); exp_q.push_back({2'b10, b}); endtask
  task automatic ex_a(input logic [7:0] b); exp_q.push_back({2'b01, b}); endtask
  task automatic start_op; cap_q.delete(); exp_q.delete(); endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (nand_ce_n == 1'b0 && n < 2000) begin tick; n++; end
    chk(nand_ce_n == 1'b1, req, "op end", nand_ce_n, 1);
  endtask

  task automatic cmp(input string req);
    bit ok = (cap_q.size() == exp_q.size());
    if (ok) foreach (exp_q[i]) if (cap_q[i] !== exp_q[i]) ok = 0;
    if (!ok) foreach (exp_q[i])
      if (i < cap_q.size()) $display("  byte %0d got %h want %h", i, cap_q[i], exp_q[i]);
    chk(ok, req, "byte stream size", cap_q.size(), exp_q.size());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (4) @(posedge clk);
    tick; rst_n = 1'b1;
    // R1 reset state
    chk(nand_ce_n && nand_we_n && !nand_cle && !nand_ale && !nand_io_oe, "R1", "pins",
        {nand_ce_n, nand_we_n, nand_cle, nand_ale, nand_io_oe}, 5'b11000);
    rd(3'd0, v); chk(v == 0, "R1", "ctrl", v, 0);
    rd(3'd1, v); chk(v == 0, "R1", "stat", v, 0);

    // R9 disabled
    wr(3'd2, mk(1, 0, 0, 0, 0, 8'hFF));
    repeat (20) tick;
    chk(rises == 0 && nand_ce_n, "R9", "pulses while disabled", rises, 0);

    wr(3'd0, 32'h1);
    // R2 lone command
    start_op; ex_c(8'hFF);
    wr(3'd2, mk(1, 0, 0, 0, 0, 8'hFF));
    wait_idle("R2"); cmp("R2");
    rd(3'd1, v); chk(v[1] == 1'b1, "R7", "done set", v, 2);
    wr(3'd1, 32'h0); rd(3'd1, v); chk(v[1] == 1'b1, "R7", "write 0 keeps", v, 2);
    wr(3'd1, 32'h2); rd(3'd1, v); chk(v[1] == 1'b0, "R7", "w1c", v, 0);

    // R3 R4 R11 full read sequence, type field 2
    wr(3'd3, 32'h44332211); wr(3'd4, 32'h55); wr(3'd5, 32'hE00530);
    start_op; ex_c(8'h00); ex_a(8'h11); ex_a(8'h22); ex_a(8'h33); ex_a(8'h44); ex_a(8'h55); ex_c(8'h30);
    wr(3'd2, mk(1, 1, 4, 1, 0, 8'h00) | 32'h8000_0000);
    wait_idle("R3"); cmp("R3 R4 R11");

    // R4 second command without first, two address cycles
    wr(3'd5, 32'hE005E0);
    start_op; ex_a(8'h11); ex_a(8'h22); ex_c(8'hE0);
    wr(3'd2, mk(0, 1, 1, 1, 0, 8'h77));
    wait_idle("R4"); cmp("R4");
    rd(3'd5, v); chk(v == 32'h00E005E0, "R5", "opset readback", v, 32'h00E005E0);

    // R3 count clamp
    start_op; ex_a(8'h11); ex_a(8'h22); ex_a(8'h33); ex_a(8'h44); ex_a(8'h55);
    wr(3'd2, mk(0, 1, 7, 0, 0, 8'h00));
    wait_idle("R3"); cmp("R3 clamp");

    // R6 settle window with ready already high
    start_op; ex_c(8'h70);
    n = rises;
    wr(3'd2, mk(1, 0, 0, 0, 1, 8'h70));
    while (rises < n + 1) tick;
    n = 0;
    while (nand_ce_n == 1'b0 && n < 100) begin tick; n++; end
    chk(n == WE_HI + SETTLE + 2, "R6", "settle cycles", n, WE_HI + SETTLE + 2);
    cmp("R6");

    // R8 busy, ignored command; R6 late release
    nand_rb_n = 1'b0;
    start_op; ex_c(8'h00); ex_a(8'h11); ex_a(8'h22); ex_a(8'h33); ex_a(8'h44); ex_a(8'h55); ex_c(8'hE0);
    wr(3'd2, mk(1, 1, 4, 1, 1, 8'h00));
    repeat (3) tick;
    wr(3'd2, mk(1, 0, 0, 0, 0, 8'h90));
    rd(3'd1, v); chk(v[4] == 1'b1, "R8", "busy bit", v, 32'h10);
    chk(nand_ce_n == 1'b0, "R8", "ce low", nand_ce_n, 0);
    repeat (80) tick;
    chk(nand_ce_n == 1'b0, "R6", "waits for ready", nand_ce_n, 0);
    nand_rb_n = 1'b1;
    repeat (3) tick;
    chk(nand_ce_n == 1'b0, "R6", "sync latency 3", nand_ce_n, 0);
    tick;
    chk(nand_ce_n == 1'b1, "R6", "sync latency 4", nand_ce_n, 1);
    repeat (20) tick;
    cmp("R8 ignored write");

    // R10 reset during wait
    nand_rb_n = 1'b0;
    wr(3'd2, mk(1, 0, 0, 0, 1, 8'hFF));
    repeat (30) tick;
    chk(nand_ce_n == 1'b0, "R10", "in wait", nand_ce_n, 0);
    wr(3'd0, 32'h3);
    rd(3'd0, v); chk(v == 32'h3, "R10", "reset flag", v, 3);
    chk(nand_ce_n == 1'b1, "R10", "aborted", nand_ce_n, 1);
    repeat (6) tick;
    rd(3'd0, v); chk(v == 32'h1, "R10", "self clear", v, 1);
    rd(3'd1, v); chk(v == 32'h0, "R10", "done cleared", v, 0);
    nand_rb_n = 1'b1;
    start_op; ex_c(8'h90);
    wr(3'd2, mk(1, 0, 0, 0, 0, 8'h90));
    wait_idle("R10"); cmp("R10 after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule